// File: doc/BRIEF.md
# Delay-Slot Fetch and Condition Sequencer

This block sits in the front end of a 16-bit processor whose branches have exactly one delay slot. On every instruction step it chooses the address of the next opcode fetch, decides whether the current instruction may store its results, and advances the program counter. The fetch always uses register values as they were at the start of the instruction. A branch rewrites the program counter only after that fetch and after the default advance. As a result, the opcode in the delay slot runs with the program counter already at the branch target.

Decoding, arithmetic and memory access live elsewhere. The decoder presents the instruction's condition, branch fields, immediate flag, branch source value, and the current contents of the return-address and testable registers. It pulses `step` for one cycle per instruction. All outputs are registered and change on the clock edge that samples `step`. They hold their values until the next step.

Top module: `dslot_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `pc`, `fetch_addr`, `imm_addr`, `ra_fetch` and `commit` to zero at the next clock edge.
- R2: On a step whose condition is not the return code and with `has_imm` low, `fetch_addr` becomes the start-of-step `pc`, and `ra_fetch` becomes 0.
- R3: On a step with condition code 2'b01 (return fetch), `fetch_addr` becomes the start-of-step `ra_in`, and `ra_fetch` becomes 1.
- R4: When no branch is taken, `pc` becomes `fetch_addr + 2`.
- R5: A taken branch sets `pc` to a target. `br_kind` 2'b00 gives start-of-step `pc + 2 + offset`. `br_kind` 2'b01 gives `pc + 2 - offset`. `br_kind` 2'b10 or 2'b11 gives the offset itself. The offset is `br_src` when `br_use_lit` is 0.
- R6: With `br_use_lit` at 1, the offset is the 6-bit cell count `br_dist` times 2, covering even byte distances from 0 to 126.
- R7: Condition 2'b10 commits only if `ts_in` is zero at the step. Condition 2'b11 commits only if it is nonzero. Codes 2'b00 and 2'b01 always commit.
- R8: A branch whose condition fails leaves `pc` at `fetch_addr + 2` and drives `commit` low.
- R9: The step after a taken branch (the delay slot) always executes and fetches from the target. If the delay slot carries the return code, `ra_in` replaces the target as its fetch address.
- R10: With `has_imm` at 1 (and no return code), `imm_addr` becomes the start-of-step `pc` and `fetch_addr` becomes that `pc + 2`. In a delay slot, the immediate is therefore read at the branch target.
- R11: While `step` is low, all outputs hold their values regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One-cycle pulse per instruction |
| cond | input | 2 | Condition: 00 always, 01 return fetch, 10 TS zero, 11 TS nonzero |
| is_branch | input | 1 | Instruction is a branch |
| br_kind | input | 2 | 00 forward, 01 backward, 10/11 absolute |
| br_use_lit | input | 1 | Use the literal cell distance instead of the source value |
| br_dist | input | 6 | Literal distance in cells |
| br_src | input | 16 | Branch source register value |
| has_imm | input | 1 | An immediate data word follows the opcode |
| ra_in | input | 16 | Return-address register at start of step |
| ts_in | input | 16 | Testable register at start of step |
| pc | output | 16 | Program counter |
| fetch_addr | output | 16 | Address of the next opcode fetch |
| imm_addr | output | 16 | Address of the immediate data word |
| ra_fetch | output | 1 | Fetch was sourced from the return address |
| commit | output | 1 | The instruction's results may be stored |

## Verification
The properties assume that `step` is a clean pulse, that `cond`, `br_kind` and the other fields are known whenever `step` is high, and that the return code never appears on an immediate-carrying step. The bench drives every field on the falling edge, raises `step` for a single cycle per instruction, and never pairs `has_imm` with the return code. Between steps it may scramble the fields, because the hold property only constrains the outputs.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CC_ALWAYS  = 2'b00,
    CC_RET     = 2'b01,
    CC_ZERO    = 2'b10,
    CC_NONZERO = 2'b11
  } seq_cond_e;

  typedef enum logic [1:0] {
    BK_FWD  = 2'b00,
    BK_BACK = 2'b01,
    BK_ABS  = 2'b10,
    BK_ABS2 = 2'b11
  } seq_brkind_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        cond_i,
  input  logic [DATA_W-1:0] ts_i,
  output logic              pass_o
);
  import seq_pkg::*;
  logic ts_zero;
  assign ts_zero = (ts_i == '0);

  always_comb begin
    case (seq_cond_e'(cond_i))
      CC_ZERO:    pass_o = ts_zero;
      CC_NONZERO: pass_o = !ts_zero;
      default:    pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/seq_fetch_sel.sv
module seq_fetch_sel #(
  parameter int ADDR_W     = 16,
  parameter int CELL_BYTES = 2
) (
  input  logic [1:0]        cond_i,
  input  logic              has_imm_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [ADDR_W-1:0] fetch_o,
  output logic [ADDR_W-1:0] imm_o,
  output logic              ra_sel_o
);
  import seq_pkg::*;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(CELL_BYTES);

  assign ra_sel_o = (seq_cond_e'(cond_i) == CC_RET);
  assign imm_o    = pc_i;

  always_comb begin
    if (ra_sel_o)       fetch_o = ra_i;
    else if (has_imm_i) fetch_o = pc_i + STEP;
    else                fetch_o = pc_i;
  end
endmodule

// File: rtl/seq_target_calc.sv
module seq_target_calc #(
  parameter int ADDR_W     = 16,
  parameter int DIST_W     = 6,
  parameter int CELL_BYTES = 2
) (
  input  logic [1:0]        kind_i,
  input  logic              use_lit_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] target_o
);
  import seq_pkg::*;
  localparam int CELL_SHIFT = $clog2(CELL_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(CELL_BYTES);

  logic [ADDR_W-1:0] lit_bytes, offset, base;

  generate
    if (DIST_W + CELL_SHIFT >= ADDR_W) begin : g_lit_trunc
      assign lit_bytes = ADDR_W'({dist_i, {CELL_SHIFT{1'b0}}});
    end else begin : g_lit_ext
      assign lit_bytes = {{(ADDR_W-DIST_W-CELL_SHIFT){1'b0}}, dist_i, {CELL_SHIFT{1'b0}}};
    end
  endgenerate

  assign offset = use_lit_i ? lit_bytes : src_i;
  assign base   = pc_i + STEP;

  always_comb begin
    case (seq_brkind_e'(kind_i))
      BK_FWD:  target_o = base + offset;
      BK_BACK: target_o = base - offset;
      default: target_o = offset;
    endcase
  end
endmodule

// File: rtl/dslot_sequencer.sv
module dslot_sequencer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int DIST_W     = 6,
  parameter int CELL_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [1:0]        cond,
  input  logic              is_branch,
  input  logic [1:0]        br_kind,
  input  logic              br_use_lit,
  input  logic [DIST_W-1:0] br_dist,
  input  logic [ADDR_W-1:0] br_src,
  input  logic              has_imm,
  input  logic [ADDR_W-1:0] ra_in,
  input  logic [DATA_W-1:0] ts_in,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] imm_addr,
  output logic              ra_fetch,
  output logic              commit
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(CELL_BYTES);

  logic [ADDR_W-1:0] pc_q, fetch_q, imm_q;
  logic              ra_q, commit_q;

  logic              pass;
  logic [ADDR_W-1:0] fetch_nx, imm_nx, target, pc_nx;
  logic              ra_nx;

  seq_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond_i (cond),
    .ts_i   (ts_in),
    .pass_o (pass)
  );

  seq_fetch_sel #(.ADDR_W(ADDR_W), .CELL_BYTES(CELL_BYTES)) u_fetch (
    .cond_i    (cond),
    .has_imm_i (has_imm),
    .pc_i      (pc_q),
    .ra_i      (ra_in),
    .fetch_o   (fetch_nx),
    .imm_o     (imm_nx),
    .ra_sel_o  (ra_nx)
  );

  seq_target_calc #(.ADDR_W(ADDR_W), .DIST_W(DIST_W), .CELL_BYTES(CELL_BYTES)) u_tgt (
    .kind_i    (br_kind),
    .use_lit_i (br_use_lit),
    .dist_i    (br_dist),
    .src_i     (br_src),
    .pc_i      (pc_q),
    .target_o  (target)
  );

  // Default advance happens first; a taken branch overrides it afterwards.
  assign pc_nx = (is_branch && pass) ? target : (fetch_nx + STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      fetch_q  <= '0;
      imm_q    <= '0;
      ra_q     <= 1'b0;
      commit_q <= 1'b0;
    end else if (step) begin
      pc_q     <= pc_nx;
      fetch_q  <= fetch_nx;
      imm_q    <= imm_nx;
      ra_q     <= ra_nx;
      commit_q <= pass;
    end
  end

  assign pc         = pc_q;
  assign fetch_addr = fetch_q;
  assign imm_addr   = imm_q;
  assign ra_fetch   = ra_q;
  assign commit     = commit_q;
endmodule

// File: rtl/dslot_sequencer_chk.sv
module dslot_sequencer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic [1:0]        cond,
  input logic              is_branch,
  input logic [1:0]        br_kind,
  input logic              br_use_lit,
  input logic [ADDR_W-1:0] br_src,
  input logic              has_imm,
  input logic [ADDR_W-1:0] ra_in,
  input logic [DATA_W-1:0] ts_in,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ra_fetch,
  input logic              commit
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && fetch_addr == '0 && !commit && !ra_fetch));

  p_fetch_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (step && cond != 2'b01 && !has_imm) |=> (fetch_addr == $past(pc) && !ra_fetch));

  p_fetch_from_ra_r3: assert property (@(posedge clk) disable iff (rst)
    (step && cond == 2'b01) |=> (fetch_addr == $past(ra_in) && ra_fetch));

  p_default_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !is_branch) |=> (pc == fetch_addr + 16'd2));

  p_abs_branch_r5: assert property (@(posedge clk) disable iff (rst)
    (step && is_branch && br_kind[1] && !br_use_lit && cond[1] == 1'b0)
      |=> (pc == $past(br_src)));

  p_zero_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (step && cond == 2'b10 && ts_in != '0) |=> !commit);

  p_nonzero_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (step && cond == 2'b11 && ts_in == '0) |=> !commit);

  p_failed_branch_r8: assert property (@(posedge clk) disable iff (rst)
    (step && is_branch && cond == 2'b10 && ts_in != '0) |=> (pc == fetch_addr + 16'd2));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc) && $stable(fetch_addr) && $stable(commit) && $stable(ra_fetch)));
endmodule

bind dslot_sequencer dslot_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .cond       (cond),
  .is_branch  (is_branch),
  .br_kind    (br_kind),
  .br_use_lit (br_use_lit),
  .br_src     (br_src),
  .has_imm    (has_imm),
  .ra_in      (ra_in),
  .ts_in      (ts_in),
  .pc         (pc),
  .fetch_addr (fetch_addr),
  .ra_fetch   (ra_fetch),
  .commit     (commit)
);

// File: tb/dslot_sequencer_tb.sv
module dslot_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [1:0]  cond = 2'b00;
  logic        is_branch = 1'b0;
  logic [1:0]  br_kind = 2'b00;
  logic        br_use_lit = 1'b0;
  logic [5:0]  br_dist = '0;
  logic [15:0] br_src = '0;
  logic        has_imm = 1'b0;
  logic [15:0] ra_in = '0;
  logic [15:0] ts_in = '0;
  logic [15:0] pc, fetch_addr, imm_addr;
  logic        ra_fetch, commit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dslot_sequencer u_dut (
    .clk(clk), .rst(rst), .step(step), .cond(cond), .is_branch(is_branch),
    .br_kind(br_kind), .br_use_lit(br_use_lit), .br_dist(br_dist), .br_src(br_src),
    .has_imm(has_imm), .ra_in(ra_in), .ts_in(ts_in), .pc(pc),
    .fetch_addr(fetch_addr), .imm_addr(imm_addr), .ra_fetch(ra_fetch), .commit(commit)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic br, input logic [1:0] k,
                       input logic lit, input logic [5:0] d, input logic [15:0] s,
                       input logic imm, input logic [15:0] ra, input logic [15:0] ts);
    @(negedge clk);
    cond = c; is_branch = br; br_kind = k; br_use_lit = lit; br_dist = d;
    br_src = s; has_imm = imm; ra_in = ra; ts_in = ts; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 pc", pc, 16'h0000);
    chk("R1 fetch", fetch_addr, 16'h0000);
    chk("R1 imm", imm_addr, 16'h0000);
    chk("R1 commit", {15'b0, commit}, 16'h0000);
    chk("R1 ra_fetch", {15'b0, ra_fetch}, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_plain;
    issue(2'b00, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0);
    chk("R2 fetch", fetch_addr, 16'h0000);
    chk("R2 ra_fetch", {15'b0, ra_fetch}, 16'h0000);
    chk("R4 pc", pc, 16'h0002);
    chk("R7 always commit", {15'b0, commit}, 16'h0001);
    issue(2'b00, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0);
    chk("R2 fetch second", fetch_addr, 16'h0002);
    chk("R4 pc second", pc, 16'h0004);
  endtask

  task automatic t_ret;
    issue(2'b01, 0, 2'b00, 0, 0, 16'h0, 0, 16'h1230, 16'h0);
    chk("R3 fetch", fetch_addr, 16'h1230);
    chk("R3 ra_fetch", {15'b0, ra_fetch}, 16'h0001);
    chk("R4 pc after ret", pc, 16'h1232);
    chk("R7 ret commit", {15'b0, commit}, 16'h0001);
  endtask

  task automatic t_branches;
    // forward literal 5 cells: 0x1232+2+10
    issue(2'b00, 1, 2'b00, 1, 6'd5, 16'hFFFF, 0, 16'h0, 16'h0);
    chk("R5 fwd fetch", fetch_addr, 16'h1232);
    chk("R6 fwd lit pc", pc, 16'h123E);
    // delay slot runs with pc at target
    issue(2'b00, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0);
    chk("R9 delay fetch", fetch_addr, 16'h123E);
    chk("R9 delay pc", pc, 16'h1240);
    // backward by register 0x20: 0x1242-0x20
    issue(2'b00, 1, 2'b01, 0, 6'd7, 16'h0020, 0, 16'h0, 16'h0);
    chk("R5 back pc", pc, 16'h1222);
    // max literal 63 cells = 126 bytes
    issue(2'b00, 1, 2'b00, 1, 6'd63, 16'h0, 0, 16'h0, 16'h0);
    chk("R6 max dist pc", pc, 16'h12A2);
    // absolute, then delay slot with return fetch
    issue(2'b00, 1, 2'b10, 0, 0, 16'h0800, 0, 16'h0, 16'h0);
    chk("R5 abs pc", pc, 16'h0800);
    issue(2'b01, 0, 2'b00, 0, 0, 16'h0, 0, 16'h4000, 16'h0);
    chk("R9 ret overrides target", fetch_addr, 16'h4000);
    chk("R9 pc after ret slot", pc, 16'h4002);
  endtask

  task automatic t_conditions;
    issue(2'b10, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0005);
    chk("R7 z fail", {15'b0, commit}, 16'h0000);
    chk("R4 pc z fail", pc, 16'h4004);
    issue(2'b10, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0000);
    chk("R7 z pass", {15'b0, commit}, 16'h0001);
    issue(2'b11, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0000);
    chk("R7 nz fail", {15'b0, commit}, 16'h0000);
    issue(2'b11, 0, 2'b00, 0, 0, 16'h0, 0, 16'h0, 16'h0009);
    chk("R7 nz pass", {15'b0, commit}, 16'h0001);
    chk("R4 pc after conds", pc, 16'h400A);
    issue(2'b10, 1, 2'b10, 0, 0, 16'h0100, 0, 16'h0, 16'h0001);
    chk("R8 failed branch pc", pc, 16'h400C);
    chk("R8 failed branch commit", {15'b0, commit}, 16'h0000);
  endtask

  task automatic t_imm;
    issue(2'b00, 0, 2'b00, 0, 0, 16'h0, 1, 16'h0, 16'h0);
    chk("R10 imm addr", imm_addr, 16'h400C);
    chk("R10 imm fetch", fetch_addr, 16'h400E);
    chk("R10 imm pc", pc, 16'h4010);
    issue(2'b00, 1, 2'b11, 0, 0, 16'h0600, 0, 16'h0, 16'h0);
    chk("R5 abs2 pc", pc, 16'h0600);
    issue(2'b00, 0, 2'b00, 0, 0, 16'h0, 1, 16'h0, 16'h0);
    chk("R10 delay imm addr", imm_addr, 16'h0600);
    chk("R10 delay imm fetch", fetch_addr, 16'h0602);
    chk("R10 delay imm pc", pc, 16'h0604);
  endtask

  task automatic t_hold;
    @(negedge clk);
    cond = 2'b01; is_branch = 1'b1; br_kind = 2'b10; br_src = 16'hBEEF;
    ra_in = 16'h7777; has_imm = 1'b1; ts_in = 16'h0; step = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 hold pc", pc, 16'h0604);
    chk("R11 hold fetch", fetch_addr, 16'h0602);
    chk("R11 hold imm", imm_addr, 16'h0600);
    chk("R11 hold ra_fetch", {15'b0, ra_fetch}, 16'h0000);
    chk("R11 hold commit", {15'b0, commit}, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_ret();
    t_branches();
    t_conditions();
    t_imm();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule